// File: doc/BRIEF.md
# DAC Frame Serializer

This block sits on the controller side of a serial link to a multi-channel DAC. It takes a channel address and a sample value through a valid/ready handshake and sends them as one framed, most-significant-bit-first bit stream on three outputs: an active-low frame select, a serial clock and a data line. The payload is the 5-bit address followed by the 14-bit value, which gives 19 bits. The payload is left-justified into three 8-bit transfers, and all three transfers run inside a single low window of the frame select.

The serial clock is derived from the system clock by a parameterised divider. The block can insert an optional low pause between bytes, as a byte-oriented master would, and a settable lead time between the frame select falling and the first clock edge. After each frame the block holds the frame select high for a minimum gap. The gap is given in nanoseconds and converted into system clock cycles. The handshake stays closed until that gap has passed. A request offered while the handshake is closed is kept waiting and is not lost.

Top module: `dac_frame_tx`

## Requirements
- R1: The 24 bits of each frame are sent in this order: the address from bit 4 down to bit 0, then the value from bit 13 down to bit 0, then the pad.
- R2: Each frame contains exactly 3 x BYTE_W = 24 serial clock rising edges, and the frame select stays low for all of them.
- R3: The serial clock is low whenever the frame select is high. During and after reset, the frame select is high, the clock is low, the data line is 0 and `req_ready` is 1.
- R4: The data line changes only in the cycle where the serial clock rises or the frame select rises, so it is stable at every falling clock edge.
- R5: Every serial clock high phase lasts HALF_DIV system cycles. Every low phase between two bits lasts HALF_DIV cycles, except after bit 8 and after bit 16, where it lasts HALF_DIV + BYTE_PAUSE cycles.
- R6: The last 5 bits of the frame (bits 20 to 24) are driven as 0.
- R7: Between two frames the frame select stays high for at least GAP_CYC = ceil(GAP_NS*1000 / CLK_PERIOD_PS) system cycles. When requests are offered back to back, it stays high for exactly GAP_CYC + 1 cycles.
- R8: `req_ready` goes low in the cycle after a request is accepted. It returns high only once the frame select has been high for GAP_CYC cycles. A request held valid while `req_ready` is low is accepted unchanged as soon as `req_ready` rises.
- R9: After the frame select falls, the clock stays low for LEAD_CYC cycles before its first rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block can accept a request this cycle |
| req_addr | input | ADDR_W | Channel address |
| req_data | input | DATA_W | Value for the addressed channel |
| dac_sync_n | output | 1 | Active-low frame select |
| dac_sclk | output | 1 | Serial clock, idles low |
| dac_din | output | 1 | Serial data, MSB first |

## Verification
The assertions assume that `rst` is held high from the first clock edge until the outputs have taken their idle values. They also assume that `req_addr` and `req_data` do not change while a request is waiting on a low `req_ready`. The bench changes its inputs only half a cycle away from the active edge. It holds the request fields constant from the moment it offers a request until the request is accepted, and it swaps in the next request only after the handshake has completed.

// File: rtl/dac_tx_pkg.sv
package dac_tx_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LEAD,
        ST_HIGH,
        ST_LOW,
        ST_PAUSE,
        ST_GAP
    } tx_state_e;

    typedef struct packed {
        logic sel_n;
        logic clk;
        logic dat;
    } line_t;

    localparam line_t LINE_IDLE = '{sel_n: 1'b1, clk: 1'b0, dat: 1'b0};

    function automatic int ceil_div(input int num, input int den);
        return (num + den - 1) / den;
    endfunction

    function automatic int ns_to_cycles(input int ns, input int period_ps);
        return ceil_div(ns * 1000, period_ps);
    endfunction

    function automatic int width_for(input int value);
        return (value < 2) ? 1 : $clog2(value + 1);
    endfunction

    function automatic int max_of(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/dac_tx_tick.sv
module dac_tx_tick #(
    parameter int CW = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic          expired
);
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired = (cnt_q == '0);

    a_r5_tick_counts_down: assert property (@(posedge clk) disable iff (rst)
        (!load && cnt_q != '0) |=> (cnt_q != $past(cnt_q)));

endmodule

// File: rtl/dac_tx_shreg.sv
module dac_tx_shreg #(
    parameter int PAYLOAD_W = 19,
    parameter int WORD_W    = 24
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 load,
    input  logic [PAYLOAD_W-1:0] payload,
    input  logic                 shift,
    output logic                 msb
);
    localparam int PAD_W = WORD_W - PAYLOAD_W;

    logic [WORD_W-1:0] fill;
    logic [WORD_W-1:0] sr_q;

    generate
        if (PAD_W > 0) begin : g_pad
            assign fill = {payload, {PAD_W{1'b0}}};
        end else begin : g_nopad
            assign fill = payload;
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            sr_q <= '0;
        end else if (load) begin
            sr_q <= fill;
        end else if (shift) begin
            sr_q <= {sr_q[WORD_W-2:0], 1'b0};
        end
    end

    assign msb = sr_q[WORD_W-1];

    a_r1_load_puts_addr_msb_first: assert property (@(posedge clk) disable iff (rst)
        load |=> (msb == $past(payload[PAYLOAD_W-1])));

endmodule

// File: rtl/dac_tx_seq.sv
module dac_tx_seq
    import dac_tx_pkg::*;
#(
    parameter int WORD_W     = 24,
    parameter int BYTE_W     = 8,
    parameter int HALF_DIV   = 2,
    parameter int LEAD_CYC   = 1,
    parameter int BYTE_PAUSE = 0,
    parameter int GAP_CYC    = 14,
    parameter int CW         = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          req_valid,
    output logic          req_ready,
    input  logic          tmr_expired,
    output logic          tmr_load,
    output logic [CW-1:0] tmr_val,
    output logic          sr_load,
    output logic          sr_shift,
    output tx_state_e     state
);
    localparam int BI_W     = $clog2(WORD_W);
    localparam int LAST_BIT = WORD_W - 1;
    localparam int PAUSE_LD = (BYTE_PAUSE > 0) ? BYTE_PAUSE - 1 : 0;

    tx_state_e       st_q, st_d;
    logic [BI_W-1:0] bit_q, bit_d;
    logic            byte_end;

    assign byte_end = ((int'(bit_q) % BYTE_W) == BYTE_W - 1);

    always_comb begin
        st_d     = st_q;
        bit_d    = bit_q;
        tmr_load = 1'b0;
        tmr_val  = '0;
        sr_load  = 1'b0;
        sr_shift = 1'b0;
        case (st_q)
            ST_IDLE: begin
                if (req_valid) begin
                    st_d     = ST_LEAD;
                    bit_d    = '0;
                    sr_load  = 1'b1;
                    tmr_load = 1'b1;
                    tmr_val  = CW'(LEAD_CYC - 1);
                end
            end
            ST_LEAD, ST_PAUSE: begin
                if (tmr_expired) begin
                    st_d     = ST_HIGH;
                    tmr_load = 1'b1;
                    tmr_val  = CW'(HALF_DIV - 1);
                end
            end
            ST_HIGH: begin
                if (tmr_expired) begin
                    st_d     = ST_LOW;
                    tmr_load = 1'b1;
                    tmr_val  = CW'(HALF_DIV - 1);
                end
            end
            ST_LOW: begin
                if (tmr_expired) begin
                    tmr_load = 1'b1;
                    if (bit_q == BI_W'(LAST_BIT)) begin
                        st_d    = ST_GAP;
                        tmr_val = CW'(GAP_CYC - 1);
                    end else begin
                        sr_shift = 1'b1;
                        bit_d    = bit_q + 1'b1;
                        if (BYTE_PAUSE > 0 && byte_end) begin
                            st_d    = ST_PAUSE;
                            tmr_val = CW'(PAUSE_LD);
                        end else begin
                            st_d    = ST_HIGH;
                            tmr_val = CW'(HALF_DIV - 1);
                        end
                    end
                end
            end
            ST_GAP: begin
                if (tmr_expired) begin
                    st_d = ST_IDLE;
                end
            end
            default: st_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= ST_IDLE;
            bit_q <= '0;
        end else begin
            st_q  <= st_d;
            bit_q <= bit_d;
        end
    end

    assign req_ready = (st_q == ST_IDLE);
    assign state     = st_q;

    a_r8_ready_drops_after_accept: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> !req_ready);

    a_r7_gap_precedes_idle: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_IDLE && $past(st_q) != ST_IDLE) |-> ($past(st_q) == ST_GAP));

endmodule

// File: rtl/dac_tx_pins.sv
module dac_tx_pins
    import dac_tx_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  tx_state_e state,
    input  logic      msb,
    output logic      sync_n,
    output logic      sclk,
    output logic      din
);
    line_t nxt, q;

    always_comb begin
        nxt.sel_n = (state == ST_IDLE) || (state == ST_GAP);
        nxt.clk   = (state == ST_HIGH);
        if (nxt.sel_n) begin
            nxt.dat = 1'b0;
        end else if (state == ST_HIGH) begin
            nxt.dat = msb;
        end else begin
            nxt.dat = q.dat;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= LINE_IDLE;
        end else begin
            q <= nxt;
        end
    end

    assign sync_n = q.sel_n;
    assign sclk   = q.clk;
    assign din    = q.dat;

    a_r3_clock_low_outside_frame: assert property (@(posedge clk) disable iff (rst)
        sync_n |-> !sclk);

    a_r4_data_moves_on_rise_only: assert property (@(posedge clk) disable iff (rst)
        (!$rose(sclk) && !$rose(sync_n)) |-> $stable(din));

    a_r9_no_clock_at_frame_start: assert property (@(posedge clk) disable iff (rst)
        $fell(sync_n) |-> !sclk);

endmodule

// File: rtl/dac_frame_tx.sv
module dac_frame_tx
    import dac_tx_pkg::*;
#(
    parameter int ADDR_W        = 5,
    parameter int DATA_W        = 14,
    parameter int BYTE_W        = 8,
    parameter int HALF_DIV      = 2,
    parameter int LEAD_CYC      = 1,
    parameter int BYTE_PAUSE    = 0,
    parameter int CLK_PERIOD_PS = 20000,
    parameter int GAP_NS        = 280
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_data,
    output logic              dac_sync_n,
    output logic              dac_sclk,
    output logic              dac_din
);
    localparam int PAYLOAD_W = ADDR_W + DATA_W;
    localparam int NUM_BYTES = ceil_div(PAYLOAD_W, BYTE_W);
    localparam int WORD_W    = NUM_BYTES * BYTE_W;
    localparam int GAP_CYC   = max_of(ns_to_cycles(GAP_NS, CLK_PERIOD_PS), 1);
    localparam int CW        = width_for(max_of(max_of(HALF_DIV, LEAD_CYC),
                                                max_of(GAP_CYC, BYTE_PAUSE)));
    localparam int RC_W      = width_for(WORD_W);
    localparam int HR_W      = width_for(GAP_CYC);

    tx_state_e     state;
    logic          tmr_load, tmr_expired, sr_load, sr_shift, msb;
    logic [CW-1:0] tmr_val;

    dac_tx_seq #(
        .WORD_W(WORD_W), .BYTE_W(BYTE_W), .HALF_DIV(HALF_DIV),
        .LEAD_CYC(LEAD_CYC), .BYTE_PAUSE(BYTE_PAUSE), .GAP_CYC(GAP_CYC), .CW(CW)
    ) u_seq (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .tmr_expired(tmr_expired), .tmr_load(tmr_load), .tmr_val(tmr_val),
        .sr_load(sr_load), .sr_shift(sr_shift), .state(state)
    );

    dac_tx_tick #(.CW(CW)) u_tick (
        .clk(clk), .rst(rst), .load(tmr_load), .load_val(tmr_val), .expired(tmr_expired)
    );

    dac_tx_shreg #(.PAYLOAD_W(PAYLOAD_W), .WORD_W(WORD_W)) u_shreg (
        .clk(clk), .rst(rst), .load(sr_load), .payload({req_addr, req_data}),
        .shift(sr_shift), .msb(msb)
    );

    dac_tx_pins u_pins (
        .clk(clk), .rst(rst), .state(state), .msb(msb),
        .sync_n(dac_sync_n), .sclk(dac_sclk), .din(dac_din)
    );

    // Output-side watchers for the frame-level assertions.
    logic            sclk_d;
    logic [RC_W-1:0] rise_cnt;
    logic [HR_W-1:0] hi_run;

    always_ff @(posedge clk) begin
        if (rst) begin
            sclk_d   <= 1'b0;
            rise_cnt <= '0;
            hi_run   <= HR_W'(GAP_CYC);
        end else begin
            sclk_d <= dac_sclk;
            if (dac_sync_n) begin
                rise_cnt <= '0;
            end else if (dac_sclk && !sclk_d) begin
                rise_cnt <= rise_cnt + 1'b1;
            end
            if (!dac_sync_n) begin
                hi_run <= '0;
            end else if (hi_run != HR_W'(GAP_CYC)) begin
                hi_run <= hi_run + 1'b1;
            end
        end
    end

    a_r2_frame_has_all_edges: assert property (@(posedge clk) disable iff (rst)
        $rose(dac_sync_n) |-> (rise_cnt == RC_W'(WORD_W)));

    a_r6_pad_bits_zero: assert property (@(posedge clk) disable iff (rst)
        (dac_sclk && !sclk_d && !dac_sync_n && rise_cnt >= RC_W'(PAYLOAD_W)) |-> !dac_din);

    a_r7_gap_kept: assert property (@(posedge clk) disable iff (rst)
        $fell(dac_sync_n) |-> (hi_run == HR_W'(GAP_CYC)));

endmodule

// File: tb/dac_frame_tx_tb.sv
module dac_frame_tx_tb;
    localparam int CLK_PERIOD = 20;
    localparam int HALF_DIV   = 2;
    localparam int LEAD_CYC   = 2;
    localparam int BYTE_PAUSE = 2;
    localparam int GAP_CYC    = 14;   // ceil(280 ns / 20 ns)
    localparam int NBITS      = 24;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [4:0]  req_addr = '0;
    logic [13:0] req_data = '0;
    logic        dac_sync_n, dac_sclk, dac_din;

    int n_chk = 0;
    int n_fail = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    dac_frame_tx #(
        .HALF_DIV(HALF_DIV), .LEAD_CYC(LEAD_CYC), .BYTE_PAUSE(BYTE_PAUSE),
        .CLK_PERIOD_PS(20000), .GAP_NS(280)
    ) u_dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_data(req_data),
        .dac_sync_n(dac_sync_n), .dac_sclk(dac_sclk), .dac_din(dac_din)
    );

    // Line monitor, samples at the falling system edge.
    int          frame_done = 0;
    int          hi_run = 1000, gap_before = 0, lead = 0, nbits = 0;
    int          hicnt = 0, lowcnt = 0, viol_din = 0, viol_sclk = 0;
    int          hiruns [NBITS];
    int          lowruns[NBITS];
    logic [23:0] cur = '0, last_frame = '0;
    int          last_nbits = 0;
    logic        seen_rise = 1'b0;
    logic        p_sync = 1'b1, p_sclk = 1'b0, p_din = 1'b0;

    always @(negedge clk) begin
        if (!rst) begin
            if (dac_sync_n) begin
                if (!p_sync) begin
                    frame_done++;
                    last_frame = cur;
                    last_nbits = nbits;
                end
                hi_run++;
                if (dac_sclk) viol_sclk++;
            end else begin
                if (p_sync) begin
                    gap_before = hi_run; hi_run = 0; nbits = 0; cur = '0;
                    lead = 0; seen_rise = 1'b0;
                end
                if (!seen_rise && !dac_sclk) lead++;
                if (dac_sclk && !p_sclk) begin
                    if (seen_rise && nbits > 0 && nbits <= NBITS) lowruns[nbits-1] = lowcnt;
                    seen_rise = 1'b1;
                    hicnt = 0;
                end
                if (dac_sclk) begin
                    hicnt++;
                    if (p_sclk && dac_din !== p_din) viol_din++;
                end
                if (!dac_sclk && p_sclk) begin
                    if (dac_din !== p_din) viol_din++;
                    cur = {cur[22:0], dac_din};
                    if (nbits < NBITS) hiruns[nbits] = hicnt;
                    nbits++;
                    lowcnt = 0;
                end else if (!dac_sclk && !p_sclk && !p_sync && dac_din !== p_din) begin
                    viol_din++;
                end
                if (!dac_sclk && seen_rise) lowcnt++;
            end
        end
        p_sync = dac_sync_n; p_sclk = dac_sclk; p_din = dac_din;
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
        #1;
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    endtask

    task automatic wait_frames(input int target);
        for (int i = 0; i < 3000 && frame_done < target; i++) step();
        chk("R2 frame completes", 32'(frame_done >= target), 32'd1);
    endtask

    task automatic check_frame(input string tag, input logic [4:0] a, input logic [13:0] d);
        chk({"R1 payload order ", tag}, {13'd0, last_frame[23:5]}, {13'd0, a, d});
        chk({"R6 pad zero ", tag}, {27'd0, last_frame[4:0]}, 32'd0);
        chk({"R2 edge count ", tag}, 32'(last_nbits), 32'(NBITS));
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (3) step();
        chk("R3 reset sync_n", 32'(dac_sync_n), 32'd1);
        chk("R3 reset sclk", 32'(dac_sclk), 32'd0);
        rst = 1'b0;
        step();
        chk("R3 idle din", 32'(dac_din), 32'd0);
        chk("R3 idle ready", 32'(req_ready), 32'd1);
    endtask

    task automatic t_single(input logic [4:0] a, input logic [13:0] d, input string tag);
        int target;
        int bad_hi, bad_lo;
        target = frame_done + 1;
        req_addr = a; req_data = d; req_valid = 1'b1;
        for (int i = 0; i < 100 && !req_ready; i++) step();
        step();
        req_valid = 1'b0;
        chk({"R8 ready low after accept ", tag}, 32'(req_ready), 32'd0);
        wait_frames(target);
        check_frame(tag, a, d);
        chk({"R9 lead ", tag}, 32'(lead), 32'(LEAD_CYC));
        bad_hi = 0; bad_lo = 0;
        for (int i = 0; i < NBITS; i++) if (hiruns[i] != HALF_DIV) bad_hi++;
        for (int i = 0; i < NBITS - 1; i++) begin
            if (i == 7 || i == 15) begin
                if (lowruns[i] != HALF_DIV + BYTE_PAUSE) bad_lo++;
            end else if (lowruns[i] != HALF_DIV) bad_lo++;
        end
        chk({"R5 high phases ", tag}, 32'(bad_hi), 32'd0);
        chk({"R5 low phases ", tag}, 32'(bad_lo), 32'd0);
        chk({"R5 byte pause ", tag}, 32'(lowruns[7]), 32'(HALF_DIV + BYTE_PAUSE));
    endtask

    task automatic t_back_to_back();
        int target;
        int waited;
        target = frame_done + 2;
        req_addr = 5'h13; req_data = 14'h0F0F; req_valid = 1'b1;
        for (int i = 0; i < 100 && !req_ready; i++) step();
        step();
        req_addr = 5'h0C; req_data = 14'h30C3;
        waited = 0;
        while (!req_ready && waited < 3000) begin
            step();
            waited++;
        end
        chk("R8 ready returns after gap", 32'(hi_run), 32'(GAP_CYC));
        check_frame("first of pair", 5'h13, 14'h0F0F);
        step();
        req_valid = 1'b0;
        chk("R8 held request accepted", 32'(req_ready), 32'd0);
        wait_frames(target);
        check_frame("held", 5'h0C, 14'h30C3);
        chk("R7 gap back to back", 32'(gap_before), 32'(GAP_CYC + 1));
        chk("R7 gap minimum", 32'(gap_before >= GAP_CYC), 32'd1);
    endtask

    task automatic t_line_rules();
        chk("R4 data stable at falling edges", 32'(viol_din), 32'd0);
        chk("R3 clock low while frame select high", 32'(viol_sclk), 32'd0);
        chk("R3 idle after traffic", 32'({dac_sync_n, dac_sclk, dac_din}), 32'b100);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual hung expected finished");
        summary();
        $finish;
    end

    initial begin
        t_reset();
        t_single(5'h00, 14'h0000, "zeros");
        t_single(5'h1F, 14'h3FFF, "ones");
        t_single(5'h15, 14'h2AAA, "alt a");
        t_single(5'h0A, 14'h1555, "alt b");
        t_single(5'h01, 14'h2001, "ends");
        t_back_to_back();
        repeat (GAP_CYC + 4) step();
        t_line_rules();
        summary();
        $finish;
    end

endmodule